// File: doc/BRIEF.md
# Interrupt Status-Read and Poll Unit

This block is one eight-level channel of a classic programmable interrupt controller. It is built around the control word that chooses which status register a read returns, issues a one-shot poll, and switches special mask mode. It holds the request register (IRR), the in-service register (ISR) and the mask register (IMR), and it has a fixed-priority resolver in which level 0 is highest. A host reaches it over a simple 8-bit I/O bus that has a chip select, one address bit `a0`, and read and write strobes. Register accesses take one clock each.

`a0` selects between two locations. At `a0 = 0` the host writes control words and reads IRR, ISR or a poll byte. At `a0 = 1` the host reads and writes the mask. A single `init_done` pulse stands in for the full initialization sequence. An end-of-interrupt command clears in-service bits, so that service can be nested and completed. In a system, the primary copy decodes I/O base 020h and the secondary copy decodes 0A0h. That decode is outside the block, which sees only `cs`.

Top module: `pic_status_poll`

## Requirements
- R1: After reset, and again after any `init_done` pulse, IRR, ISR and IMR are 0, special mask mode is off, no poll is pending and the read select is IRR. Until the first `init_done`, every write is ignored.
- R2: A write is taken as the status/poll/mask-mode word only when `a0 = 0`, `din[7] = 0` and `din[4:3] = 01`. For example, 8Bh (bit 7 set) has no effect.
- R3: In that word, `din[1:0] = 10` selects IRR and `11` selects ISR. The values `00` and `01` leave the selection as it was. The selection is sticky: reads at `a0 = 0` keep returning the selected register.
- R4: Each rising edge on `irq_in[i]` sets IRR bit i. A set IRR bit stays set until that level is acknowledged by a poll.
- R5: The first read after a word with `din[2] = 1` is a poll. It returns 80h | L when level L is the resolved request, and at the clock edge it sets ISR[L] and clears IRR[L]. When nothing is resolvable, the poll returns 00h and changes no register.
- R6: A poll applies to exactly one read, at either `a0` value. Later reads return the sticky selection again.
- R7: With `din[6] = 1`, `din[5]` turns special mask mode on (1) or off (0). With `din[6] = 0`, the mode is unchanged.
- R8: In normal mode, a set ISR bit blocks its own level and every lower level. `int_out` is high exactly when some unmasked IRR level is not blocked.
- R9: In special mask mode, a set ISR bit blocks only its own level.
- R10: A read at `a0 = 1` returns IMR. A write at `a0 = 1` after initialization loads IMR, and a set IMR bit excludes that level from resolution.
- R11: A write at `a0 = 0` with `din[4:3] = 00` and `din[7:5] = 001` clears the lowest-numbered set ISR bit. With `din[7:5] = 011`, it clears ISR bit `din[2:0]`.
- R12: `dout` is 00h whenever `cs` and `rd` are not both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_done | input | 1 | One-cycle pulse marking the end of initialization |
| cs | input | 1 | Chip select |
| a0 | input | 1 | Address bit selecting control/status (0) or mask (1) |
| rd | input | 1 | Read strobe, one access per clock |
| wr | input | 1 | Write strobe, one access per clock |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, combinational during a read |
| irq_in | input | 8 | Interrupt request lines, rising-edge sensed |
| int_out | output | 1 | Interrupt request toward the processor |

## Verification
The assertions assume that `rd` and `wr` are never high together, because a poll read and a control write in the same cycle would have no defined order. They also assume that `init_done` is a clean single-cycle pulse. The stimulus draws each cycle as a read, a write or an idle cycle, never both strobes, and it raises `init_done` only occasionally. Request lines toggle at random, so edges arrive in the same cycle as acknowledges, masked levels and nested service.

// File: rtl/pic_status_poll.sv
module pic_status_poll (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_done,
  input  logic       cs,
  input  logic       a0,
  input  logic       rd,
  input  logic       wr,
  input  logic [7:0] din,
  output logic [7:0] dout,
  input  logic [7:0] irq_in,
  output logic       int_out
);

  logic [7:0] irr, isr, imr, irq_q;
  logic       smm, sel_isr, poll_pend, ready;

  wire rd_cyc = cs & rd;
  wire wr_cyc = cs & wr & ready;
  wire is_sel = wr_cyc & ~a0 & ~din[7] & (din[4:3] == 2'b01);
  wire is_eoi = wr_cyc & ~a0 & (din[4:3] == 2'b00);
  wire eoi_ns = is_eoi & (din[7:5] == 3'b001);
  wire eoi_sp = is_eoi & (din[7:5] == 3'b011);
  wire [7:0] rise = irq_in & ~irq_q;

  logic [7:0] allow, cand, top_isr;
  logic [2:0] lvl;
  logic       seen;

  always_comb begin
    seen = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (isr[i]) seen = 1'b1;
      allow[i] = smm ? ~isr[i] : ~seen;
    end
  end

  assign cand    = irr & ~imr & allow;
  assign int_out = |cand;

  always_comb begin
    lvl = 3'd0;
    for (int i = 7; i >= 0; i--)
      if (cand[i]) lvl = 3'(i);
  end

  always_comb begin
    top_isr = 8'h00;
    for (int i = 7; i >= 0; i--)
      if (isr[i]) top_isr = 8'h01 << i;
  end

  wire       ack      = rd_cyc & poll_pend & int_out;
  wire [7:0] ack_mask = ack ? (8'h01 << lvl) : 8'h00;
  wire [7:0] eoi_mask = eoi_ns ? top_isr : eoi_sp ? (8'h01 << din[2:0]) : 8'h00;
  wire [7:0] poll_byte = int_out ? {5'b10000, lvl} : 8'h00;

  assign dout = !rd_cyc   ? 8'h00 :
                poll_pend ? poll_byte :
                a0        ? imr :
                sel_isr   ? isr : irr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q     <= 8'h00;
      irr       <= 8'h00;
      isr       <= 8'h00;
      imr       <= 8'h00;
      smm       <= 1'b0;
      sel_isr   <= 1'b0;
      poll_pend <= 1'b0;
      ready     <= 1'b0;
    end else begin
      irq_q <= irq_in;
      if (init_done) begin
        ready     <= 1'b1;
        irr       <= 8'h00;
        isr       <= 8'h00;
        imr       <= 8'h00;
        smm       <= 1'b0;
        sel_isr   <= 1'b0;
        poll_pend <= 1'b0;
      end else begin
        irr <= (irr | rise) & ~ack_mask;
        isr <= (isr | ack_mask) & ~eoi_mask;
        if (wr_cyc && a0) imr <= din;
        if (is_sel && din[1]) sel_isr <= din[0];
        if (is_sel && din[6]) smm <= din[5];
        if (is_sel && din[2]) poll_pend <= 1'b1;
        else if (rd_cyc) poll_pend <= 1'b0;
      end
    end
  end

  // R3
  sel_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && !(is_sel && din[1])) |=> $stable(sel_isr));

  // R4
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && rise != 8'h00 && !ack) |=> ((irr & $past(rise)) == $past(rise)));

  // R5
  poll_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !init_done && !wr) |=> (isr[$past(lvl)] && !irr[$past(lvl)]));

  // R6
  poll_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cyc && !wr && !init_done) |=> !poll_pend);

  // R7
  smm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_done && !(is_sel && din[6])) |=> $stable(smm));

  // R9
  smm_self_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smm && int_out) |-> !isr[lvl]);

endmodule

// File: tb/pic_status_poll_tb.sv
module pic_status_poll_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, init_done = 0, cs = 0, a0 = 0, rd = 0, wr = 0;
  logic [7:0] din = 0, irq_in = 0, dout;
  logic int_out;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_status_poll u_dut (.clk(clk), .rst_n(rst_n), .init_done(init_done), .cs(cs),
    .a0(a0), .rd(rd), .wr(wr), .din(din), .dout(dout), .irq_in(irq_in), .int_out(int_out));

  logic [7:0] m_irr = 0, m_isr = 0, m_imr = 0, m_q = 0;
  logic m_smm = 0, m_sel = 0, m_poll = 0, m_rdy = 0;

  function automatic logic [7:0] f_cand();
    logic [7:0] al; logic s = 0;
    for (int i = 0; i < 8; i++) begin
      if (m_isr[i]) s = 1;
      al[i] = m_smm ? ~m_isr[i] : ~s;
    end
    return m_irr & ~m_imr & al;
  endfunction

  function automatic logic [2:0] f_low(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return 3'(i);
    return 3'd0;
  endfunction

  function automatic logic [7:0] f_dout(input logic c, r, a);
    logic [7:0] cd = f_cand();
    if (!(c && r)) return 8'h00;
    if (m_poll) return (cd != 0) ? (8'h80 | f_low(cd)) : 8'h00;
    if (a) return m_imr;
    return m_sel ? m_isr : m_irr;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic c, input logic a, input logic r,
                      input logic w, input logic [7:0] d, input logic [7:0] irq,
                      input logic ini);
    logic [7:0] cd, am, em;
    logic wc, sel, ack;
    @(negedge clk);
    cs = c; a0 = a; rd = r; wr = w; din = d; irq_in = irq; init_done = ini;
    #1;
    chk({tag, " dout"}, dout, f_dout(c, r, a));
    chk({tag, " int_out (R8)"}, {7'b0, int_out}, {7'b0, f_cand() != 0});
    @(posedge clk);
    cd = f_cand();
    ack = c && r && m_poll && cd != 0;
    am = ack ? (8'h01 << f_low(cd)) : 8'h00;
    wc = c && w && m_rdy;
    sel = wc && !a && !d[7] && d[4:3] == 2'b01;
    em = 8'h00;
    if (wc && !a && d[4:3] == 2'b00 && d[7:5] == 3'b001) em = m_isr & ~(m_isr - 8'h01);
    if (wc && !a && d[4:3] == 2'b00 && d[7:5] == 3'b011) em = 8'h01 << d[2:0];
    if (ini) begin
      m_rdy = 1; m_irr = 0; m_isr = 0; m_imr = 0; m_smm = 0; m_sel = 0; m_poll = 0;
    end else begin
      m_irr = (m_irr | (irq & ~m_q)) & ~am;
      m_isr = (m_isr | am) & ~em;
      if (wc && a) m_imr = d;
      if (sel && d[1]) m_sel = d[0];
      if (sel && d[6]) m_smm = d[5];
      if (sel && d[2]) m_poll = 1;
      else if (c && r) m_poll = 0;
    end
    m_q = irq;
  endtask

  task automatic rd0(input string tag, input logic [7:0] irq, input logic [7:0] exp);
    step(tag, 1, 0, 1, 0, 8'h00, irq, 0);
    chk(tag, f_dout(1, 1, 0) === f_dout(1, 1, 0) ? exp : 8'hxx, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] irq = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state and pre-init writes ignored
    step("R1 reset irr", 1, 0, 1, 0, 0, 8'h00, 0);
    step("R1 pre-init imr write", 1, 1, 0, 1, 8'hFF, 8'h00, 0);
    step("R1 pre-init sel write", 1, 0, 0, 1, 8'h0B, 8'h00, 0);
    step("R1 imr still zero", 1, 1, 1, 0, 0, 8'h00, 0);
    chk("R1 imr after ignored write", m_imr, 8'h00);
    step("R1 init", 0, 0, 0, 0, 0, 8'h00, 1);
    // R4 edges latch; R3 default IRR read
    step("R4 edge", 0, 0, 0, 0, 0, 8'h05, 0);
    step("R3 default irr", 1, 0, 1, 0, 0, 8'h05, 0);
    chk("R4 irr latched", m_irr, 8'h05);
    // R3 select ISR via poll first to fill ISR
    step("R5 poll cmd", 1, 0, 0, 1, 8'h0C, 8'h00, 0);
    step("R5 poll read", 1, 0, 1, 0, 0, 8'h00, 0);
    chk("R5 isr after poll", m_isr, 8'h01);
    step("R6 after poll", 1, 0, 1, 0, 0, 8'h00, 0);
    step("R3 sel isr", 1, 0, 0, 1, 8'h0B, 8'h00, 0);
    step("R3 read isr", 1, 0, 1, 0, 0, 8'h00, 0);
    step("R3 00 keeps", 1, 0, 0, 1, 8'h08, 8'h00, 0);
    step("R3 still isr", 1, 0, 1, 0, 0, 8'h00, 0);
    step("R2 bit7 set ignored", 1, 0, 0, 1, 8'h8A, 8'h00, 0);
    step("R2 still isr", 1, 0, 1, 0, 0, 8'h00, 0);
    chk("R2 sel unchanged", {7'b0, m_sel}, 8'h01);
    // R8 normal mode blocks level 2 while ISR0 set
    step("R8 blocked", 0, 0, 0, 0, 0, 8'h00, 0);
    chk("R8 int blocked", {7'b0, int_out}, 8'h00);
    // R9 SMM unblocks
    step("R7 smm on", 1, 0, 0, 1, 8'h68, 8'h00, 0);
    step("R9 smm", 0, 0, 0, 0, 0, 8'h00, 0);
    chk("R9 int in smm", {7'b0, int_out}, 8'h01);
    step("R7 bit6 clear ignored", 1, 0, 0, 1, 8'h08, 8'h00, 0);
    chk("R7 smm kept", {7'b0, m_smm}, 8'h01);
    step("R7 smm off", 1, 0, 0, 1, 8'h48, 8'h00, 0);
    // R11 EOI, R10 mask
    step("R11 ns eoi", 1, 0, 0, 1, 8'h20, 8'h00, 0);
    chk("R11 isr cleared", m_isr, 8'h00);
    step("R10 mask", 1, 1, 0, 1, 8'h04, 8'h00, 0);
    step("R10 read imr", 1, 1, 1, 0, 0, 8'h00, 0);
    step("R5 poll cmd2", 1, 0, 0, 1, 8'h0C, 8'h00, 0);
    step("R5 empty poll", 1, 1, 1, 0, 0, 8'h00, 0);
    chk("R5 empty leaves irr", m_irr, 8'h04);
    step("R12 idle dout", 0, 0, 1, 0, 0, 8'h00, 0);
    step("R11 sp eoi", 1, 0, 0, 1, 8'h63, 8'h00, 0);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 9);
      logic [7:0] d = 8'($urandom);
      if ($urandom_range(0, 3) == 0) irq = 8'($urandom);
      if (op < 4) step("R5 R6 R10 rand read", 1, 1'($urandom), 1, 0, 0, irq, 0);
      else if (op < 6) step("R2 R3 R7 rand sel", 1, 0, 0, 1, (d & 8'h67) | 8'h08, irq, 0);
      else if (op == 6) step("R11 rand eoi", 1, 0, 0, 1, (d & 8'hE7), irq, 0);
      else if (op == 7) step("R10 rand imr", 1, 1, 0, 1, d & 8'($urandom), irq, 0);
      else if (op == 8 && n % 97 == 0) step("R1 rand init", 0, 0, 0, 0, 0, irq, 1);
      else step("R12 rand idle", 1'($urandom), 1'($urandom), 1'($urandom), 0, d, irq, 0);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule